// File: doc/BRIEF.md
# SMI Cause Flag Bank

This block keeps a set of sticky cause flags that explain why a system management interrupt was requested. Event pulses arrive from several sources: messages from the upstream hub (one SMI-class, one SCI-class), a watchdog that has expired, software writes to the inbound and outbound data registers, redirected NMI events, illegal attempts to write the firmware region, and a year rollover in the real-time-clock domain. Each flag stays set until software writes a 1 to its bit. The combined `smi_req` output is high while any flag is set.

The block decodes bus write attempts against the protected firmware window at the top of the address space. A 4 MB lower alias of that window is excluded. The block also watches the write-protect control for a rising transition while the lock control is set. The century flag lives in the slower RTC clock domain. Its clear request crosses into that domain through a synchronized request/acknowledge handshake, and its value comes back through a two-flop synchronizer. The NMI-redirect flag is read-only and follows the underlying NMI status.

Top module: `smi_status_bank`

## Requirements
- R1: The bus-domain flags are sticky, and each clears only when 1 is written to its bit in `reg_wdata` with `reg_wr` high. Writing 0 leaves the flag unchanged. The bit map is: bit 1 = `indat_wr`, bit 2 = `outdat_wr`, bit 3 = `wdt_zero`, bit 9 = `hub_sci_msg`, bit 10 = `hub_smi_msg`. A flag reads back set on `reg_rdata` one clock after its pulse.
- R2: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R3: Bit 8 (firmware write violation) sets when `fw_wp` goes from 0 to 1 while `fw_lock` is 1. The same rising transition with `fw_lock` at 0 does not set it.
- R4: Bit 8 sets on a write (`mem_wr_valid`) whose address lies in the top `FW_BYTES` of the address space while `fw_wp` is 1. The same write with `fw_wp` at 0 does not set it.
- R5: A write into the alias window, which lies `ALIAS_OFS` (4 MB) below the firmware window, never sets bit 8.
- R6: Bit 7 (century) sets when the BCD year sampled on `rtc_clk` changes from 8'h99 to 8'h00. It becomes visible on `reg_rdata` after the bus-side synchronizer.
- R7: Writing 1 to bit 7 clears the century flag through the RTC-domain handshake. The flag still reads 1 in the cycle right after the write and reads 0 once the clear has crossed. Asserting `rtc_rst_n` low also clears the flag.
- R8: Bits 6:4 and 15:11 of `reg_rdata` always read 0, even after writes of 1 to them.
- R9: Bit 0 sets when `nmi_evt` pulses while `nmi_redir_en` is 1. It stays set while `nmi_pending` is 1, ignores writes, and clears in the cycle after `nmi_pending` falls to 0. It does not set when `nmi_redir_en` is 0.
- R10: `smi_req` is 1 exactly when at least one readable flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Bus-domain asynchronous active-low reset |
| rtc_clk | input | 1 | RTC-domain clock |
| rtc_rst_n | input | 1 | RTC-domain asynchronous active-low reset; clears the century flag |
| hub_smi_msg | input | 1 | Pulse: SMI-class message from the hub |
| hub_sci_msg | input | 1 | Pulse: SCI-class message from the hub |
| wdt_zero | input | 1 | Pulse: watchdog reached zero |
| outdat_wr | input | 1 | Pulse: write to the outbound data register |
| indat_wr | input | 1 | Pulse: write to the inbound data register |
| nmi_evt | input | 1 | Pulse: event that would raise an NMI |
| nmi_redir_en | input | 1 | Redirect NMI events to SMI |
| nmi_pending | input | 1 | Underlying NMI status level |
| fw_wp | input | 1 | Firmware write-protect control |
| fw_lock | input | 1 | Firmware lock-down control |
| mem_wr_valid | input | 1 | A memory write is being attempted |
| mem_wr_addr | input | AW | Address of the attempted write |
| year_bcd | input | 8 | BCD year value, RTC domain |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data (1 = clear) |
| reg_rdata | output | 16 | Register read data |
| smi_req | output | 1 | Combined SMI request |

## Verification
The table walk sets each pulse-driven source on its own, so that a wrong bit position shows up as a wrong bit rather than a missing one. It then mixes zero writes, partial clear masks and a set that coincides with its own clear, which separates true write-one-to-clear behaviour from write-zero clearing and clear-wins priority. The firmware tests cover the window, the alias and a protect-off write, and a protect rise with and without lock, so each qualifying term of the violation check is tested in isolation. The century tests check both the delayed clear path and the RTC reset path. The NMI tests separate a read-only flag from a writable one.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int REG_W    = 16;
  localparam int POS_NMI  = 0;
  localparam int POS_IN   = 1;
  localparam int POS_OUT  = 2;
  localparam int POS_WDT  = 3;
  localparam int POS_CENT = 7;
  localparam int POS_FW   = 8;
  localparam int POS_SCI  = 9;
  localparam int POS_SMI  = 10;
  localparam int N_STICKY = 6;

  // bit position of each sticky bus-domain flag, by slot index
  function automatic int sticky_pos(input int idx);
    case (idx)
      0:       return POS_IN;
      1:       return POS_OUT;
      2:       return POS_WDT;
      3:       return POS_SCI;
      4:       return POS_SMI;
      default: return POS_FW;
    endcase
  endfunction

  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'((1 << POS_NMI) | (1 << POS_IN) | (1 << POS_OUT) | (1 << POS_WDT) |
           (1 << POS_CENT) | (1 << POS_FW) | (1 << POS_SCI) | (1 << POS_SMI));
endpackage

// File: rtl/smi_sync2.sv
module smi_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/smi_sticky_flag.sv
module smi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R1: a set flag survives any cycle without a clear
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);
  // R2: a set event always leaves the flag set
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
endmodule

// File: rtl/smi_fw_guard.sv
module smi_fw_guard #(
  parameter int          AW        = 32,
  parameter longint      FW_BYTES  = 64'h0010_0000,
  parameter longint      ALIAS_OFS = 64'h0040_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp,
  input  logic          lock,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  output logic          viol
);
  localparam longint TOP_ADDR = 64'(1) << AW;
  localparam logic [AW:0] WIN_LO   = (AW+1)'(TOP_ADDR - FW_BYTES);
  localparam logic [AW:0] ALIAS_LO = (AW+1)'(TOP_ADDR - FW_BYTES - ALIAS_OFS);
  localparam logic [AW:0] ALIAS_HI = (AW+1)'(TOP_ADDR - ALIAS_OFS);

  logic wp_q;
  logic wp_rise;
  logic win_hit;
  logic alias_hit;
  logic [AW:0] addr_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= 1'b0;
    else        wp_q <= wp;
  end

  always_comb begin
    addr_x    = {1'b0, wr_addr};
    wp_rise   = wp && !wp_q;
    win_hit   = addr_x >= WIN_LO;
    alias_hit = (addr_x >= ALIAS_LO) && (addr_x < ALIAS_HI);
    viol      = (wp_rise && lock) ||
                (wr_valid && wp && win_hit && !alias_hit);
  end

  // R5: an alias write alone never yields a violation
  p_alias_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && alias_hit && !(lock && wp && !wp_q) |-> !viol);
endmodule

// File: rtl/smi_century_rtc.sv
module smi_century_rtc (
  input  logic       rtc_clk,
  input  logic       rtc_rst_n,
  input  logic [7:0] year_bcd,
  input  logic       clr_lvl,
  output logic       flag
);
  logic [7:0] year_q;
  logic       clr_lvl_q;
  logic       flag_q;
  logic       flag_d;
  logic       roll;
  logic       clr_edge;

  always_comb begin
    roll     = (year_q == 8'h99) && (year_bcd == 8'h00);
    clr_edge = clr_lvl && !clr_lvl_q;
    flag_d   = flag_q;
    if (clr_edge) flag_d = 1'b0;
    if (roll)     flag_d = 1'b1;
  end

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      year_q    <= 8'h00;
      clr_lvl_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      year_q    <= year_bcd;
      clr_lvl_q <= clr_lvl;
      flag_q    <= flag_d;
    end
  end

  assign flag = flag_q;

  // R6: a 99 -> 00 step of the year sets the flag
  p_rollover_r6: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (year_q == 8'h99) && (year_bcd == 8'h00) |=> flag_q);
  // R7: only a fresh clear request drops the flag
  p_cent_hold_r7: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    flag_q && !(clr_lvl && !clr_lvl_q) |=> flag_q);
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank
  import smi_pkg::*;
#(
  parameter int     AW        = 32,
  parameter longint FW_BYTES  = 64'h0010_0000,
  parameter longint ALIAS_OFS = 64'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_clk,
  input  logic             rtc_rst_n,
  input  logic             hub_smi_msg,
  input  logic             hub_sci_msg,
  input  logic             wdt_zero,
  input  logic             outdat_wr,
  input  logic             indat_wr,
  input  logic             nmi_evt,
  input  logic             nmi_redir_en,
  input  logic             nmi_pending,
  input  logic             fw_wp,
  input  logic             fw_lock,
  input  logic             mem_wr_valid,
  input  logic [AW-1:0]    mem_wr_addr,
  input  logic [7:0]       year_bcd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             smi_req
);
  logic                fw_viol;
  logic [N_STICKY-1:0] stk_set;
  logic [N_STICKY-1:0] stk_flag;

  // ---- firmware protection check
  smi_fw_guard #(.AW(AW), .FW_BYTES(FW_BYTES), .ALIAS_OFS(ALIAS_OFS)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp       (fw_wp),
    .lock     (fw_lock),
    .wr_valid (mem_wr_valid),
    .wr_addr  (mem_wr_addr),
    .viol     (fw_viol)
  );

  // ---- sticky write-one-to-clear flags, slot order matches sticky_pos()
  assign stk_set = {fw_viol, hub_smi_msg, hub_sci_msg, wdt_zero, outdat_wr, indat_wr};

  for (genvar gi = 0; gi < N_STICKY; gi++) begin : g_stk
    smi_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (stk_set[gi]),
      .clr   (reg_wr && reg_wdata[sticky_pos(gi)]),
      .flag  (stk_flag[gi])
    );
  end

  // ---- read-only NMI redirect flag
  logic nmi_flag_q;
  logic nmi_flag_d;

  always_comb begin
    nmi_flag_d = (nmi_evt && nmi_redir_en) || (nmi_flag_q && nmi_pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_flag_q <= 1'b0;
    else        nmi_flag_q <= nmi_flag_d;
  end

  // ---- century flag: clear request handshake into the RTC domain
  logic cent_req_q, cent_req_d;
  logic cent_pend_q, cent_pend_d;
  logic cent_launch;
  logic cent_wr;
  logic req_rtc;
  logic ack_bus;
  logic cent_rtc;
  logic cent_bus;

  always_comb begin
    cent_wr     = reg_wr && reg_wdata[POS_CENT];
    cent_launch = !cent_req_q && !ack_bus && (cent_pend_q || cent_wr);
    cent_pend_d = (cent_pend_q || cent_wr) && !cent_launch;
    cent_req_d  = cent_req_q ? !ack_bus : cent_launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cent_req_q  <= 1'b0;
      cent_pend_q <= 1'b0;
    end else begin
      cent_req_q  <= cent_req_d;
      cent_pend_q <= cent_pend_d;
    end
  end

  smi_sync2 #(.W(1)) u_req_sync (
    .clk (rtc_clk), .rst_n (rtc_rst_n), .d (cent_req_q), .q (req_rtc)
  );

  smi_century_rtc u_cent (
    .rtc_clk   (rtc_clk),
    .rtc_rst_n (rtc_rst_n),
    .year_bcd  (year_bcd),
    .clr_lvl   (req_rtc),
    .flag      (cent_rtc)
  );

  smi_sync2 #(.W(2)) u_back_sync (
    .clk (clk), .rst_n (rst_n), .d ({req_rtc, cent_rtc}), .q ({ack_bus, cent_bus})
  );

  // ---- register view and combined request
  always_comb begin
    reg_rdata           = '0;
    reg_rdata[POS_NMI]  = nmi_flag_q;
    reg_rdata[POS_CENT] = cent_bus;
    for (int k = 0; k < N_STICKY; k++) reg_rdata[sticky_pos(k)] = stk_flag[k];
    smi_req = |(reg_rdata & LIVE_MASK);
  end

  logic unused_wdata;
  assign unused_wdata = ^(reg_wdata & ~LIVE_MASK) ^ reg_wdata[POS_NMI];

  // R3/R4: the violation flag can only rise while write-protect is on
  p_fw_needs_wp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[POS_FW]) |-> $past(fw_wp));
  // R9: without pending NMI status and without a new event the flag is low
  p_nmi_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_pending && !(nmi_evt && nmi_redir_en) |=> !reg_rdata[POS_NMI]);
  // R7: a launched clear request is held until it is acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cent_req_q && !ack_bus |=> cent_req_q);
endmodule

// File: tb/test_smi_status_bank.sv
module test_smi_status_bank;
  logic        clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_rst_n = 1'b0;
  logic        hub_smi_msg = 1'b0, hub_sci_msg = 1'b0, wdt_zero = 1'b0;
  logic        outdat_wr = 1'b0, indat_wr = 1'b0;
  logic        nmi_evt = 1'b0, nmi_redir_en = 1'b0, nmi_pending = 1'b0;
  logic        fw_wp = 1'b0, fw_lock = 1'b0, mem_wr_valid = 1'b0;
  logic [31:0] mem_wr_addr = 32'h0;
  logic [7:0]  year_bcd = 8'h00;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        smi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #15.5 rtc_clk = ~rtc_clk;

  smi_status_bank i_smi_status_bank (
    .clk (clk), .rst_n (rst_n), .rtc_clk (rtc_clk), .rtc_rst_n (rtc_rst_n),
    .hub_smi_msg (hub_smi_msg), .hub_sci_msg (hub_sci_msg), .wdt_zero (wdt_zero),
    .outdat_wr (outdat_wr), .indat_wr (indat_wr), .nmi_evt (nmi_evt),
    .nmi_redir_en (nmi_redir_en), .nmi_pending (nmi_pending), .fw_wp (fw_wp),
    .fw_lock (fw_lock), .mem_wr_valid (mem_wr_valid), .mem_wr_addr (mem_wr_addr),
    .year_bcd (year_bcd), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .smi_req (smi_req)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [15:0] exp);
    check(reg_rdata === exp, req, reg_rdata, exp);
    check(smi_req === (exp != 16'h0), {req, "/R10 smi"}, {15'h0, smi_req}, {15'h0, exp != 16'h0});
    check((reg_rdata & 16'hF870) === 16'h0, {req, "/R8 reserved"}, reg_rdata & 16'hF870, 16'h0);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic w1c(input logic [15:0] mask);
    reg_wr = 1'b1; reg_wdata = mask; tick(); reg_wr = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rtc_year(input logic [7:0] y);
    @(negedge rtc_clk); year_bcd = y; @(negedge rtc_clk); @(negedge rtc_clk);
  endtask

  // {ev[4:0] = smi,sci,wdt,out,in ; wr ; wdata ; expected rdata}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {5'b00001, 1'b0, 16'h0000, 16'h0002},  // R1 in  -> bit1
    {5'b00010, 1'b0, 16'h0000, 16'h0006},  // R1 out -> bit2
    {5'b00100, 1'b0, 16'h0000, 16'h000E},  // R1 wdt -> bit3
    {5'b01000, 1'b0, 16'h0000, 16'h020E},  // R1 sci -> bit9
    {5'b10000, 1'b0, 16'h0000, 16'h060E},  // R1 smi -> bit10
    {5'b00000, 1'b1, 16'h0000, 16'h060E},  // R1 write 0 ignored
    {5'b00000, 1'b1, 16'h0004, 16'h060A},  // R1 single clear
    {5'b00000, 1'b1, 16'h0608, 16'h0002},  // R1 partial mask
    {5'b00001, 1'b1, 16'h0002, 16'h0002},  // R2 set beats clear
    {5'b00000, 1'b1, 16'h0002, 16'h0000},  // R1 clear last
    {5'b01000, 1'b1, 16'h0000, 16'h0200},  // R1 sci alone
    {5'b00000, 1'b1, 16'h0200, 16'h0000}   // R1 clear sci
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge rtc_clk); rtc_rst_n = 1'b1;
    tick();
    chk_reg("R10 reset", 16'h0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      {hub_smi_msg, hub_sci_msg, wdt_zero, outdat_wr, indat_wr} = VEC[i][37:33];
      reg_wr = VEC[i][32]; reg_wdata = VEC[i][31:16];
      tick();
      {hub_smi_msg, hub_sci_msg, wdt_zero, outdat_wr, indat_wr} = 5'b0;
      reg_wr = 1'b0; reg_wdata = 16'h0;
      chk_reg($sformatf("R1 vec%0d", i), VEC[i][15:0]);
    end

    // firmware protection
    fw_wp = 1'b1; tick(); tick();
    chk_reg("R3 rise without lock", 16'h0000);
    mem_wr_valid = 1'b1; mem_wr_addr = 32'hFFFF_F000; tick(); mem_wr_valid = 1'b0;
    chk_reg("R4 window write", 16'h0100);
    w1c(16'h0100);
    chk_reg("R4 cleared", 16'h0000);
    mem_wr_valid = 1'b1; mem_wr_addr = 32'hFFBF_F000; tick(); mem_wr_valid = 1'b0;
    chk_reg("R5 alias write", 16'h0000);
    mem_wr_valid = 1'b1; mem_wr_addr = 32'hFFEF_FFFC; tick(); mem_wr_valid = 1'b0;
    chk_reg("R4 below window", 16'h0000);
    fw_wp = 1'b0; tick();
    mem_wr_valid = 1'b1; mem_wr_addr = 32'hFFF0_0000; tick(); mem_wr_valid = 1'b0;
    chk_reg("R4 unprotected write", 16'h0000);
    fw_lock = 1'b1; tick();
    fw_wp = 1'b1; tick();
    chk_reg("R3 rise with lock", 16'h0100);
    w1c(16'hF970);
    chk_reg("R8 reserved write", 16'h0000);
    fw_wp = 1'b0; fw_lock = 1'b0; tick();

    // NMI redirect
    nmi_redir_en = 1'b1; nmi_pending = 1'b1; nmi_evt = 1'b1; tick(); nmi_evt = 1'b0;
    chk_reg("R9 redirect set", 16'h0001);
    w1c(16'h0001);
    chk_reg("R9 write ignored", 16'h0001);
    nmi_pending = 1'b0; tick();
    chk_reg("R9 follows status", 16'h0000);
    nmi_redir_en = 1'b0; nmi_pending = 1'b1; nmi_evt = 1'b1; tick(); nmi_evt = 1'b0;
    chk_reg("R9 redirect off", 16'h0000);
    nmi_pending = 1'b0; tick();

    // century rollover
    rtc_year(8'h98); rtc_year(8'h99);
    repeat (4) tick();
    chk_reg("R6 no early set", 16'h0000);
    rtc_year(8'h00);
    repeat (4) tick();
    chk_reg("R6 rollover", 16'h0080);
    w1c(16'h0080);
    chk_reg("R7 clear delayed", 16'h0080);
    repeat (40) tick();
    chk_reg("R7 cleared", 16'h0000);
    rtc_year(8'h99); rtc_year(8'h00);
    repeat (4) tick();
    chk_reg("R6 second rollover", 16'h0080);
    @(negedge rtc_clk); rtc_rst_n = 1'b0;
    @(negedge rtc_clk); @(negedge rtc_clk); rtc_rst_n = 1'b1;
    repeat (4) tick();
    chk_reg("R7 rtc reset", 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule